// File: doc/BRIEF.md
# Multi-Core Global Timer with Per-Core Comparators

The block keeps one 64-bit up-counter shared by every processor core. The counter advances once every (divider + 1) clock cycles while the timer is running. Each core has its own comparator bank. A bank holds a 64-bit match value, a 32-bit re-arm step, a sticky match flag and an interrupt line. A bank signals a match once the shared count is equal to or greater than its match value. It can then move its match value forward by the step, so periodic events need no software help.

Software reaches the block through a 32-bit word-only register port. The port has one 32-byte window per core and one alias window. The alias window sends each access to the bank of the core that issues it, as given by the `req_core` input. The request address is `{window, offset[4:0]}`: window 0 is the alias, and window k+1 is core k. The control word combines global fields with fields that are banked per core. Reads return data one cycle after the request.

Top module: `mc_global_timer`

## Requirements
- R1: While the run bit is set, the counter increments by one every (DIV+1) clock cycles, DIV being control bits 15:8. The divider phase restarts when the timer is started, and the carry from the low word into the high word is exact.
- R2: A write to the counter words (offset 0x00 low, 0x04 high) changes the counter only while the run bit is clear. While the run bit is set, such a write is dropped.
- R3: Control (offset 0x08) bit 0 is run and bits 15:8 are DIV, both global. Bit 1 is match enable, bit 2 is interrupt enable and bit 3 is re-arm, all banked per core. A read returns the global bits OR the addressed core's banked bits, and every other bit reads 0. A write sets the global bits and the banked bits of the addressed core only.
- R4: A bank's match flag (offset 0x0C, bit 0) is set on a clock edge only if run is set, the bank's match enable is set, and count >= match value (offsets 0x10 low, 0x14 high).
- R5: On a match with re-arm set, the match value grows by the zero-extended 32-bit step (offset 0x18) once per match. With re-arm clear, the match value does not change.
- R6: Writing 1 to flag bit 0 clears the flag. Writing 0 leaves it unchanged. A match in the same cycle as a clear takes priority.
- R7: Each irq bit equals the bank's flag AND its interrupt enable, registered one cycle later.
- R8: Window k+1 addresses core k. Window 0 addresses the core given by req_core.
- R9: Offsets 0x1C and above, offsets that are not word aligned, windows beyond the last core, and alias accesses from a core ID of NUM_CORES or more all read as 0 and ignore writes.
- R10: After reset, all registers of every core, the counter and the global control read 0, and irq is 0.
- R11: Each read request gives exactly one rsp_valid pulse, on the cycle after the request. It carries the register state from before that cycle's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | WIN_W+5 | {window, byte offset} |
| req_wdata | input | 32 | Write data |
| req_core | input | CID_W | ID of the requesting core (used by the alias window) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq | output | NUM_CORES | Per-core interrupt lines |

## Verification
The bench runs the timer for exact cycle windows, with a divider of 3 and with a divider of 0 across the low-word carry. An off-by-one divider, or a phase that carries over from before the start, would leave a different count. It hits a match value exactly, to catch a strict greater-than compare. It counts re-arm steps, which shows whether the match value moves once per match or sticks. It also writes the counter while the timer is running, checks that a clear written as 0 keeps the flag, and checks that a control write from one core leaves the other core's banked bits alone. Alias accesses must land on the bank picked by req_core. Out-of-range windows and alias IDs must not reach a real bank.

// File: rtl/gt_pkg.sv
package gt_pkg;

  localparam int WORD_W = 32;
  localparam int CNT_W  = 64;
  localparam int OFS_W  = 5;
  localparam int DIV_W  = 8;

  localparam logic [OFS_W-1:0] OFS_CNT_LO = 5'h00;
  localparam logic [OFS_W-1:0] OFS_CNT_HI = 5'h04;
  localparam logic [OFS_W-1:0] OFS_CTRL   = 5'h08;
  localparam logic [OFS_W-1:0] OFS_FLAG   = 5'h0C;
  localparam logic [OFS_W-1:0] OFS_MAT_LO = 5'h10;
  localparam logic [OFS_W-1:0] OFS_MAT_HI = 5'h14;
  localparam logic [OFS_W-1:0] OFS_STEP   = 5'h18;

  localparam int CB_RUN    = 0;
  localparam int CB_MEN    = 1;
  localparam int CB_IEN    = 2;
  localparam int CB_REARM  = 3;
  localparam int CB_DIV_LO = 8;

  typedef struct packed {
    logic [CNT_W-1:0]  match;
    logic [WORD_W-1:0] step;
    logic              flag;
    logic              men;
    logic              ien;
    logic              rearm;
  } bank_view_t;

  typedef struct packed {
    logic ctrl;
    logic flag;
    logic mat_lo;
    logic mat_hi;
    logic step;
  } bank_wr_t;

endpackage

// File: rtl/gt_prescaled_counter.sv
module gt_prescaled_counter
  import gt_pkg::*;
#(
  parameter int DIV_BITS = DIV_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  logic [DIV_BITS-1:0] div,
  input  logic                ld_lo,
  input  logic                ld_hi,
  input  logic [WORD_W-1:0]   ld_data,
  output logic [CNT_W-1:0]    count
);

  localparam int HALF = CNT_W / 2;

  logic [DIV_BITS-1:0] phase_q;
  logic [CNT_W-1:0]    count_q;
  logic                tick;

  assign tick  = (phase_q == div);
  assign count = count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      count_q <= '0;
    end else if (run) begin
      if (tick) begin
        phase_q <= '0;
        count_q <= count_q + 1'b1;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end else begin
      phase_q <= '0;
      if (ld_lo) count_q[HALF-1:0]     <= ld_data;
      if (ld_hi) count_q[CNT_W-1:HALF] <= ld_data;
    end
  end

endmodule

// File: rtl/gt_cmp_bank.sv
module gt_cmp_bank
  import gt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [CNT_W-1:0]  count,
  input  bank_wr_t          wr,
  input  logic [WORD_W-1:0] wdata,
  output bank_view_t        view,
  output logic              irq
);

  localparam int HALF = CNT_W / 2;

  logic [CNT_W-1:0]  match_q;
  logic [WORD_W-1:0] step_q;
  logic              flag_q;
  logic              men_q;
  logic              ien_q;
  logic              rearm_q;
  logic              irq_q;
  logic              hit;

  assign hit = run & men_q & (count >= match_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= '0;
      step_q  <= '0;
      flag_q  <= 1'b0;
      men_q   <= 1'b0;
      ien_q   <= 1'b0;
      rearm_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (wr.ctrl) begin
        men_q   <= wdata[CB_MEN];
        ien_q   <= wdata[CB_IEN];
        rearm_q <= wdata[CB_REARM];
      end
      if (hit)
        flag_q <= 1'b1;
      else if (wr.flag && wdata[0])
        flag_q <= 1'b0;
      if (wr.mat_lo)
        match_q[HALF-1:0] <= wdata;
      else if (wr.mat_hi)
        match_q[CNT_W-1:HALF] <= wdata;
      else if (hit && rearm_q)
        match_q <= match_q + {{(CNT_W-WORD_W){1'b0}}, step_q};
      if (wr.step)
        step_q <= wdata;
      irq_q <= flag_q & ien_q;
    end
  end

  assign view = '{match: match_q, step: step_q, flag: flag_q,
                  men: men_q, ien: ien_q, rearm: rearm_q};
  assign irq  = irq_q;

endmodule

// File: rtl/gt_reg_decode.sv
module gt_reg_decode
  import gt_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int WIN_W     = 3,
  parameter int CID_W     = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [WIN_W+OFS_W-1:0]  req_addr,
  input  logic [WORD_W-1:0]       req_wdata,
  input  logic [CID_W-1:0]        req_core,
  input  logic                    run,
  input  logic [DIV_W-1:0]        div,
  input  logic [CNT_W-1:0]        count,
  input  bank_view_t              views [NUM_CORES],
  output bank_wr_t                bank_wr [NUM_CORES],
  output logic                    glb_wr,
  output logic                    cnt_wr_lo,
  output logic                    cnt_wr_hi,
  output logic                    rsp_valid,
  output logic [WORD_W-1:0]       rsp_rdata
);

  localparam int HALF = CNT_W / 2;
  localparam logic [WIN_W-1:0] LAST_WIN = WIN_W'(NUM_CORES);
  localparam logic [CID_W:0]   CORE_LIM = (CID_W+1)'(NUM_CORES);

  logic [WIN_W-1:0] win;
  logic [OFS_W-1:0] ofs;
  logic [WIN_W-1:0] tgt;
  logic             tgt_ok;
  logic             aligned;
  logic             acc;
  logic             wr;
  bank_view_t       sel;
  logic [WORD_W-1:0] rd_mux;
  logic             rsp_valid_q;
  logic [WORD_W-1:0] rsp_rdata_q;

  assign win     = req_addr[WIN_W+OFS_W-1:OFS_W];
  assign ofs     = req_addr[OFS_W-1:0];
  assign aligned = (ofs[1:0] == 2'b00);
  assign tgt     = (win == '0) ? WIN_W'(req_core) : (win - 1'b1);
  assign tgt_ok  = (win == '0) ? ({1'b0, req_core} < CORE_LIM) : (win <= LAST_WIN);
  assign acc     = req_valid & tgt_ok & aligned;
  assign wr      = acc & req_write;

  assign glb_wr    = wr && (ofs == OFS_CTRL);
  assign cnt_wr_lo = wr && (ofs == OFS_CNT_LO);
  assign cnt_wr_hi = wr && (ofs == OFS_CNT_HI);

  generate
    for (genvar i = 0; i < NUM_CORES; i++) begin : g_wr
      logic me;
      assign me = wr && (tgt == WIN_W'(i));
      assign bank_wr[i] = '{ctrl:   me && (ofs == OFS_CTRL),
                            flag:   me && (ofs == OFS_FLAG),
                            mat_lo: me && (ofs == OFS_MAT_LO),
                            mat_hi: me && (ofs == OFS_MAT_HI),
                            step:   me && (ofs == OFS_STEP)};
    end
  endgenerate

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_CORES; i++)
      if (tgt == WIN_W'(i)) sel = views[i];
  end

  always_comb begin
    rd_mux = '0;
    if (tgt_ok && aligned) begin
      case (ofs)
        OFS_CNT_LO: rd_mux = count[HALF-1:0];
        OFS_CNT_HI: rd_mux = count[CNT_W-1:HALF];
        OFS_CTRL: begin
          rd_mux[CB_RUN]                   = run;
          rd_mux[CB_MEN]                   = sel.men;
          rd_mux[CB_IEN]                   = sel.ien;
          rd_mux[CB_REARM]                 = sel.rearm;
          rd_mux[CB_DIV_LO+DIV_W-1:CB_DIV_LO] = div;
        end
        OFS_FLAG:   rd_mux[0] = sel.flag;
        OFS_MAT_LO: rd_mux = sel.match[HALF-1:0];
        OFS_MAT_HI: rd_mux = sel.match[CNT_W-1:HALF];
        OFS_STEP:   rd_mux = sel.step;
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= req_valid & ~req_write;
      rsp_rdata_q <= (req_valid & ~req_write) ? rd_mux : '0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

endmodule

// File: rtl/mc_global_timer.sv
module mc_global_timer
  import gt_pkg::*;
#(
  parameter int MAX_CORES = 4,
  parameter int NUM_CORES = 2,
  parameter int CID_W     = (MAX_CORES > 1) ? $clog2(MAX_CORES) : 1,
  parameter int WIN_W     = $clog2(MAX_CORES + 1),
  parameter int ADDR_W    = WIN_W + OFS_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [WORD_W-1:0]    req_wdata,
  input  logic [CID_W-1:0]     req_core,
  output logic                 rsp_valid,
  output logic [WORD_W-1:0]    rsp_rdata,
  output logic [NUM_CORES-1:0] irq
);

  logic             run_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] count;
  logic             glb_wr;
  logic             cnt_wr_lo;
  logic             cnt_wr_hi;
  bank_view_t       views   [NUM_CORES];
  bank_wr_t         bank_wr [NUM_CORES];
  logic [NUM_CORES-1:0] flag_v;
  logic [NUM_CORES-1:0] ien_v;
  logic [NUM_CORES-1:0] men_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      div_q <= '0;
    end else if (glb_wr) begin
      run_q <= req_wdata[CB_RUN];
      div_q <= req_wdata[CB_DIV_LO+DIV_W-1:CB_DIV_LO];
    end
  end

  gt_prescaled_counter #(.DIV_BITS(DIV_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .run     (run_q),
    .div     (div_q),
    .ld_lo   (cnt_wr_lo),
    .ld_hi   (cnt_wr_hi),
    .ld_data (req_wdata),
    .count   (count)
  );

  gt_reg_decode #(
    .NUM_CORES (NUM_CORES),
    .WIN_W     (WIN_W),
    .CID_W     (CID_W)
  ) u_dec (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_core  (req_core),
    .run       (run_q),
    .div       (div_q),
    .count     (count),
    .views     (views),
    .bank_wr   (bank_wr),
    .glb_wr    (glb_wr),
    .cnt_wr_lo (cnt_wr_lo),
    .cnt_wr_hi (cnt_wr_hi),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  generate
    for (genvar i = 0; i < NUM_CORES; i++) begin : g_bank
      gt_cmp_bank u_bank (
        .clk   (clk),
        .rst   (rst),
        .run   (run_q),
        .count (count),
        .wr    (bank_wr[i]),
        .wdata (req_wdata),
        .view  (views[i]),
        .irq   (irq[i])
      );
      assign flag_v[i] = views[i].flag;
      assign ien_v[i]  = views[i].ien;
      assign men_v[i]  = views[i].men;
    end
  endgenerate

endmodule

// File: rtl/gt_timer_checker.sv
module gt_timer_checker #(
  parameter int NUM_CORES = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 run,
  input logic [63:0]          count,
  input logic                 cnt_wr,
  input logic                 req_valid,
  input logic                 req_write,
  input logic                 rsp_valid,
  input logic [NUM_CORES-1:0] flag_v,
  input logic [NUM_CORES-1:0] ien_v,
  input logic [NUM_CORES-1:0] men_v,
  input logic [NUM_CORES-1:0] irq
);

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    run |=> (count == $past(count) || count == $past(count) + 64'd1));

  // R2
  count_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_wr) |=> $stable(count));

  // R11
  rsp_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rsp_valid);

  // R11
  rsp_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && !req_write));

  generate
    for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
      // R4
      flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_v[i]) |-> $past(run && men_v[i]));

      // R7
      irq_on_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_v[i] && ien_v[i]) |=> irq[i]);

      // R7
      irq_off_chk: assert property (@(posedge clk) disable iff (rst)
        !(flag_v[i] && ien_v[i]) |=> !irq[i]);
    end
  endgenerate

endmodule

bind mc_global_timer gt_timer_checker #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .run       (run_q),
  .count     (count),
  .cnt_wr    (cnt_wr_lo | cnt_wr_hi),
  .req_valid (req_valid),
  .req_write (req_write),
  .rsp_valid (rsp_valid),
  .flag_v    (flag_v),
  .ien_v     (ien_v),
  .men_v     (men_v),
  .irq       (irq)
);

// File: tb/mc_global_timer_bench.sv
module mc_global_timer_bench;

  localparam int NC = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  req_core = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NC-1:0] irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  mc_global_timer #(.MAX_CORES(4), .NUM_CORES(NC)) u_mc_global_timer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_core(req_core),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: each access occupies one clock edge, driven at the negedge.
  task automatic wr(input int win, input logic [4:0] ofs, input int core, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1;
    req_addr = {3'(win), ofs}; req_core = 2'(core); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input int win, input logic [4:0] ofs, input int core,
                    input logic [31:0] exp, input string tag);
    req_valid = 1'b1; req_write = 1'b0;
    req_addr = {3'(win), ofs}; req_core = 2'(core); req_wdata = '0;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops one expected item for each response (R11).
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11: unexpected response %h expected none", rsp_rdata);
      end else begin
        check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(1);
    @(negedge clk);
    idle(2);
    rst = 1'b0;
    idle(1);

    // R10 reset state
    check("R10 irq", 32'(irq), 32'h0);
    for (int w = 0; w < 3; w++)
      for (int o = 0; o < 7; o++)
        rd(w, 5'(o * 4), 0, 32'h0, "R10 reset value");

    // R3 global/banked control mix
    wr(1, 5'h08, 0, 32'hFFFF_030E);
    rd(1, 5'h08, 0, 32'h0000_030E, "R3 core0 control");
    rd(2, 5'h08, 0, 32'h0000_0300, "R3 core1 sees global only");
    wr(2, 5'h08, 0, 32'h0000_0304);
    rd(1, 5'h08, 0, 32'h0000_030E, "R3 core0 banked kept");
    rd(2, 5'h08, 0, 32'h0000_0304, "R3 core1 control");

    // R9 unmapped and misaligned
    wr(1, 5'h1C, 0, 32'hDEAD_BEEF);
    rd(1, 5'h1C, 0, 32'h0, "R9 offset 0x1C");
    rd(1, 5'h0A, 0, 32'h0, "R9 misaligned");
    wr(3, 5'h08, 0, 32'h0000_0001);
    wr(0, 5'h08, 3, 32'h0000_0001);
    rd(3, 5'h08, 0, 32'h0, "R9 window past last core");
    rd(0, 5'h08, 3, 32'h0, "R9 alias bad core id");
    rd(1, 5'h08, 0, 32'h0000_030E, "R9 control untouched");

    // R2 load while stopped, R1 divider 3
    wr(1, 5'h00, 0, 32'hFFFF_FFF0);
    wr(1, 5'h04, 0, 32'h0000_0001);
    rd(1, 5'h00, 0, 32'hFFFF_FFF0, "R2 load low");
    rd(1, 5'h04, 0, 32'h0000_0001, "R2 load high");
    wr(1, 5'h08, 0, 32'h0000_0301);   // start, edge E
    wr(1, 5'h00, 0, 32'h0000_0000);   // ignored while running
    idle(18);
    wr(1, 5'h08, 0, 32'h0000_0300);   // stop, edge E+20
    rd(1, 5'h00, 0, 32'hFFFF_FFF5, "R1 divide by 4 / R2 write while running ignored");
    rd(1, 5'h04, 0, 32'h0000_0001, "R1 high word");

    // R1 carry with divider 0
    wr(1, 5'h00, 0, 32'hFFFF_FFFE);
    wr(1, 5'h08, 0, 32'h0000_0001);
    idle(2);
    wr(1, 5'h08, 0, 32'h0000_0000);
    rd(1, 5'h00, 0, 32'h0000_0001, "R1 carry low");
    rd(1, 5'h04, 0, 32'h0000_0002, "R1 carry high");

    // R4 R5 R7: core0 periodic match
    wr(1, 5'h00, 0, 32'h0);
    wr(1, 5'h04, 0, 32'h0);
    wr(1, 5'h10, 0, 32'd10);
    wr(1, 5'h18, 0, 32'd5);
    wr(0, 5'h08, 0, 32'h0000_000F);   // edge E
    idle(19);
    wr(0, 5'h08, 0, 32'h0000_000E);   // edge E+20
    check("R7 irq core0 only", 32'(irq), 32'h1);
    rd(1, 5'h00, 0, 32'd20, "R1 count after run");
    rd(1, 5'h10, 0, 32'd20, "R5 two re-arm steps");
    rd(1, 5'h0C, 0, 32'h1, "R4 flag on equal/greater");
    rd(2, 5'h0C, 0, 32'h0, "R4 no flag without match enable");

    // R6 write-one-to-clear
    wr(1, 5'h0C, 0, 32'h0);
    rd(1, 5'h0C, 0, 32'h1, "R6 zero keeps flag");
    wr(1, 5'h0C, 0, 32'h1);
    rd(1, 5'h0C, 0, 32'h0, "R6 one clears flag");
    check("R7 irq drops", 32'(irq), 32'h0);

    // R5 no re-arm on core1, R8 alias
    wr(2, 5'h08, 0, 32'h0000_0007);   // one counted edge
    wr(2, 5'h08, 0, 32'h0000_0006);
    rd(0, 5'h0C, 1, 32'h1, "R8 alias core1 flag");
    rd(2, 5'h10, 0, 32'h0, "R5 match kept without re-arm");
    rd(1, 5'h10, 0, 32'd25, "R5 core0 third step");
    rd(1, 5'h00, 0, 32'd21, "R1 single step");
    check("R7 irq both", 32'(irq), 32'h3);
    wr(0, 5'h10, 1, 32'h0000_1234);
    rd(2, 5'h10, 0, 32'h0000_1234, "R8 alias write to core1");
    rd(1, 5'h10, 0, 32'd25, "R8 core0 untouched");
    rd(0, 5'h18, 0, 32'd5, "R8 alias core0 step");

    idle(3);
    check("R11 all responses seen", 32'(exp_q.size()), 32'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule